// File: doc/BRIEF.md
# SPI FIFO Occupancy and Request Router

This block keeps the bookkeeping for the two data queues of an SPI peripheral. It does not hold the storage arrays or the shifter. For each direction it tracks a 4-bit fill level, a pointer to the next entry to leave the queue, and the address where an arriving word is to be stored. It turns the push and pop strobes from the bus side and from the shifter side into store and read enables for the arrays around it. It detects receive overflow and transmit underflow, and it keeps sticky event flags that software clears by writing ones.

Two level flags come out of the block: "transmit has room" and "receive has data". Each can be enabled, and each is steered either to the shared interrupt line or to its own DMA request line. The overflow, underflow, end-of-queue and transfer-done flags only raise the interrupt. When a receive word arrives at a full queue, a mode input decides what happens to it. In drop mode the word is discarded. In overwrite mode it replaces the most recently stored entry. Either direction can be reduced to a single-entry buffer.

Top module: `spi_fifo_flags`

## Requirements
- R1: After reset, both levels, both next pointers and all four sticky flags are 0. The room flag is 1, the data flag is 0, and the interrupt and both DMA lines are low.
- R2: A push is accepted only while the level is below the capacity. An accepted push raises the store enable at the current write position and advances that position. A pop is accepted only while the level is nonzero; it raises the read enable and advances the next pointer. The level rises by accepted pushes and falls by accepted pops, so a push and a pop in the same cycle leave it unchanged. Positions wrap from DEPTH-1 to 0.
- R3: A clear pulse on either direction sets that direction's level, next pointer and write position to 0 at the next edge. It overrides any push or pop in the same cycle.
- R4: The data flag is 1 exactly when the receive level is nonzero. The room flag is 1 exactly when the transmit level is below capacity.
- R5: A receive push at full capacity sets sticky flag bit 0 (overflow) and leaves the receive level unchanged. In drop mode (overwrite input 0) the store enable stays low.
- R6: In overwrite mode (overwrite input 1), a receive push at full capacity raises the store enable with the address of the most recently written entry, which is the write position minus one, wrapping from 0 to DEPTH-1.
- R7: A shifter pop on an empty transmit queue sets sticky flag bit 1 (underflow). It raises no read enable and leaves the level at 0.
- R8: Sticky flag bits are: 0 overflow, 1 underflow, 2 end of queue, 3 transfer done. A write with a mask clears each bit whose mask bit is 1, but a set event on that bit in the same cycle wins.
- R9: An enabled room or data flag goes to the interrupt when its select is 0, and to its own DMA line when its select is 1. It never goes to both.
- R10: A sticky flag raises the interrupt only while its enable bit (same bit position) is 1. No sticky flag drives a DMA line.
- R11: With a direction's single-entry input at 1, capacity is 1 and that direction's positions stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clear | input | 1 | Empty the transmit queue (pulse) |
| rx_clear | input | 1 | Empty the receive queue (pulse) |
| tx_single | input | 1 | Transmit acts as one-entry buffer |
| rx_single | input | 1 | Receive acts as one-entry buffer |
| rx_overwrite | input | 1 | Overflow policy: 0 drop, 1 overwrite newest |
| bus_tx_push | input | 1 | Bus writes a transmit word |
| shf_tx_pop | input | 1 | Shifter needs a transmit frame |
| shf_rx_push | input | 1 | Shifter delivers a received frame |
| bus_rx_pop | input | 1 | Bus reads a received word |
| eoq_evt | input | 1 | End-of-queue event from the shifter |
| done_evt | input | 1 | Transfer-done event from the shifter |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for the sticky flags |
| flag_clr_mask | input | 4 | Bits to clear |
| fill_en | input | 1 | Enable room-flag request |
| fill_to_dma | input | 1 | Room request: 0 interrupt, 1 DMA |
| drain_en | input | 1 | Enable data-flag request |
| drain_to_dma | input | 1 | Data request: 0 interrupt, 1 DMA |
| flag_irq_en | input | 4 | Interrupt enables for the sticky flags |
| tx_count | output | 4 | Transmit level |
| tx_next_ptr | output | 4 | Next transmit entry to send |
| tx_store_en | output | 1 | Write transmit array |
| tx_store_addr | output | 4 | Transmit array write address |
| tx_load_en | output | 1 | Transmit entry handed to the shifter |
| rx_count | output | 4 | Receive level |
| rx_pop_ptr | output | 4 | Next receive entry to be read |
| rx_store_en | output | 1 | Write receive array |
| rx_store_addr | output | 4 | Receive array write address |
| rx_read_en | output | 1 | Receive entry returned to the bus |
| fill_flag | output | 1 | Transmit has room |
| drain_flag | output | 1 | Receive has data |
| flags | output | 4 | Sticky flags |
| irq | output | 1 | Interrupt request |
| dma_fill_req | output | 1 | DMA request to refill transmit |
| dma_drain_req | output | 1 | DMA request to drain receive |

## Verification
Directed runs cover several patterns. Filling past capacity separates accepting a push from dropping it. Draining past empty separates a real pop from an underflow. A simultaneous push and pop shows that the level holds while both positions move. Receive pushes at full capacity in each mode separate drop from overwrite and show the wrap of the rewrite address. Clear pulses and mask writes that coincide with set events show which side has priority. Single-entry mode shows that the positions stay put. A long stretch of random strobes, enables and selects is then compared against a behavioural model on every clock. That stretch exercises wrap-around, routing and interrupt masking in mixed orders.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int CNT_W  = 4;
  localparam int FLAG_N = 4;
  localparam int F_OVF  = 0;
  localparam int F_UNF  = 1;
  localparam int F_EOQ  = 2;
  localparam int F_DONE = 3;

  // Capacity in effect: one entry when reduced, otherwise the full depth.
  function automatic logic [CNT_W-1:0] fifo_cap(input logic single,
                                                input logic [CNT_W-1:0] depth);
    return single ? CNT_W'(1) : depth;
  endfunction

  // Advance a position, wrapping at the depth; held at 0 in one-entry mode.
  function automatic logic [CNT_W-1:0] ptr_step(input logic [CNT_W-1:0] p,
                                                input logic single,
                                                input logic [CNT_W-1:0] depth);
    if (single) return '0;
    return (p >= depth - CNT_W'(1)) ? '0 : p + CNT_W'(1);
  endfunction

  // Position written most recently, i.e. one behind the write position.
  function automatic logic [CNT_W-1:0] ptr_back(input logic [CNT_W-1:0] p,
                                                input logic single,
                                                input logic [CNT_W-1:0] depth);
    if (single) return '0;
    return (p == '0) ? depth - CNT_W'(1) : p - CNT_W'(1);
  endfunction
endpackage

// File: rtl/sfr_occupancy.sv
module sfr_occupancy
  import sfr_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter bit REPORT_SPACE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             single,
  input  logic             allow_overwrite,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] store_addr,
  output logic             store_en,
  output logic             rd_en,
  output logic             wr_hit_full,
  output logic             rd_hit_empty,
  output logic             level_flag
);
  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

  logic [CNT_W-1:0] wr_ptr;
  logic [CNT_W-1:0] cap;
  logic             full;
  logic             empty;
  logic             wr_ok;

  always_comb begin
    cap          = fifo_cap(single, DEPTH_V);
    full         = (count >= cap);
    empty        = (count == '0);
    wr_ok        = wr_req & ~full;
    rd_en        = rd_req & ~empty;
    wr_hit_full  = wr_req & full;
    rd_hit_empty = rd_req & empty;
    store_en     = wr_ok | (wr_hit_full & allow_overwrite);
    store_addr   = wr_ok ? wr_ptr : ptr_back(wr_ptr, single, DEPTH_V);
  end

  generate
    if (REPORT_SPACE) begin : g_space
      assign level_flag = ~full;
    end else begin : g_data
      assign level_flag = ~empty;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clear) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      count <= count + CNT_W'(wr_ok) - CNT_W'(rd_en);
      if (wr_ok) wr_ptr <= ptr_step(wr_ptr, single, DEPTH_V);
      if (rd_en) rd_ptr <= ptr_step(rd_ptr, single, DEPTH_V);
    end
  end
endmodule

// File: rtl/sfr_sticky.sv
module sfr_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flags[i] <= 1'b0;
        else if (set_evt[i]) flags[i] <= 1'b1;
        else if (clr_we && clr_mask[i]) flags[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/sfr_router.sv
module sfr_router #(
  parameter int N = 4
) (
  input  logic         fill_flag,
  input  logic         drain_flag,
  input  logic [N-1:0] flags,
  input  logic         fill_en,
  input  logic         fill_to_dma,
  input  logic         drain_en,
  input  logic         drain_to_dma,
  input  logic [N-1:0] flag_irq_en,
  output logic         irq,
  output logic         dma_fill_req,
  output logic         dma_drain_req
);
  logic fill_req, drain_req;

  always_comb begin
    fill_req      = fill_flag & fill_en;
    drain_req     = drain_flag & drain_en;
    dma_fill_req  = fill_req & fill_to_dma;
    dma_drain_req = drain_req & drain_to_dma;
    irq = (|(flags & flag_irq_en))
        | (fill_req & ~fill_to_dma)
        | (drain_req & ~drain_to_dma);
  end
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
  import sfr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_clear,
  input  logic             rx_clear,
  input  logic             tx_single,
  input  logic             rx_single,
  input  logic             rx_overwrite,
  input  logic             bus_tx_push,
  input  logic             shf_tx_pop,
  input  logic             shf_rx_push,
  input  logic             bus_rx_pop,
  input  logic             eoq_evt,
  input  logic             done_evt,
  input  logic             flag_clr_we,
  input  logic [3:0]       flag_clr_mask,
  input  logic             fill_en,
  input  logic             fill_to_dma,
  input  logic             drain_en,
  input  logic             drain_to_dma,
  input  logic [3:0]       flag_irq_en,
  output logic [3:0]       tx_count,
  output logic [3:0]       tx_next_ptr,
  output logic             tx_store_en,
  output logic [3:0]       tx_store_addr,
  output logic             tx_load_en,
  output logic [3:0]       rx_count,
  output logic [3:0]       rx_pop_ptr,
  output logic             rx_store_en,
  output logic [3:0]       rx_store_addr,
  output logic             rx_read_en,
  output logic             fill_flag,
  output logic             drain_flag,
  output logic [3:0]       flags,
  output logic             irq,
  output logic             dma_fill_req,
  output logic             dma_drain_req
);
  // Named internal events, visible to the bound checker.
  logic              tx_unf_evt;
  logic              rx_ovf_evt;
  logic              tx_ovf_unused;
  logic              rx_unf_unused;
  logic [FLAG_N-1:0] set_evt;

  sfr_occupancy #(.DEPTH(DEPTH), .REPORT_SPACE(1'b1)) u_tx (
    .clk, .rst_n,
    .clear           (tx_clear),
    .single          (tx_single),
    .allow_overwrite (1'b0),
    .wr_req          (bus_tx_push),
    .rd_req          (shf_tx_pop),
    .count           (tx_count),
    .rd_ptr          (tx_next_ptr),
    .store_addr      (tx_store_addr),
    .store_en        (tx_store_en),
    .rd_en           (tx_load_en),
    .wr_hit_full     (tx_ovf_unused),
    .rd_hit_empty    (tx_unf_evt),
    .level_flag      (fill_flag)
  );

  sfr_occupancy #(.DEPTH(DEPTH), .REPORT_SPACE(1'b0)) u_rx (
    .clk, .rst_n,
    .clear           (rx_clear),
    .single          (rx_single),
    .allow_overwrite (rx_overwrite),
    .wr_req          (shf_rx_push),
    .rd_req          (bus_rx_pop),
    .count           (rx_count),
    .rd_ptr          (rx_pop_ptr),
    .store_addr      (rx_store_addr),
    .store_en        (rx_store_en),
    .rd_en           (rx_read_en),
    .wr_hit_full     (rx_ovf_evt),
    .rd_hit_empty    (rx_unf_unused),
    .level_flag      (drain_flag)
  );

  always_comb begin
    set_evt         = '0;
    set_evt[F_OVF]  = rx_ovf_evt;
    set_evt[F_UNF]  = tx_unf_evt;
    set_evt[F_EOQ]  = eoq_evt;
    set_evt[F_DONE] = done_evt;
  end

  sfr_sticky #(.N(FLAG_N)) u_sticky (
    .clk, .rst_n,
    .set_evt  (set_evt),
    .clr_we   (flag_clr_we),
    .clr_mask (flag_clr_mask),
    .flags    (flags)
  );

  sfr_router #(.N(FLAG_N)) u_router (
    .fill_flag, .drain_flag, .flags,
    .fill_en, .fill_to_dma, .drain_en, .drain_to_dma, .flag_irq_en,
    .irq, .dma_fill_req, .dma_drain_req
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int DEPTH = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_clear,
  input logic       rx_clear,
  input logic       tx_single,
  input logic       rx_overwrite,
  input logic       bus_tx_push,
  input logic       shf_tx_pop,
  input logic       shf_rx_push,
  input logic       bus_rx_pop,
  input logic       flag_clr_we,
  input logic [3:0] flag_clr_mask,
  input logic       fill_en,
  input logic       fill_to_dma,
  input logic       drain_en,
  input logic       drain_to_dma,
  input logic [3:0] tx_count,
  input logic [3:0] tx_next_ptr,
  input logic       tx_load_en,
  input logic [3:0] rx_count,
  input logic       rx_store_en,
  input logic       drain_flag,
  input logic [3:0] flags,
  input logic       dma_fill_req,
  input logic       dma_drain_req,
  input logic       tx_unf_evt,
  input logic       rx_ovf_evt
);
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_count) <= DEPTH) && (32'(rx_count) <= DEPTH));

  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clear |=> (tx_count == 4'd0) && (tx_next_ptr == 4'd0));

  a_r4_data_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_rx_push && !rx_ovf_evt && !rx_clear) |=> drain_flag);

  a_r5_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_evt |=> flags[0]);

  a_r5_drop_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_evt && !rx_overwrite) |-> !rx_store_en);

  a_r5_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_evt && !bus_rx_pop && !rx_clear) |=> $stable(rx_count));

  a_r6_overwrite_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_evt && rx_overwrite) |-> rx_store_en);

  a_r7_underflow_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    tx_unf_evt |-> !tx_load_en);

  a_r7_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_unf_evt |=> flags[1]);

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_tx_pop && tx_count == 4'd0 && flag_clr_we && flag_clr_mask[1]) |=> flags[1]);

  a_r9_fill_dma_route: assert property (@(posedge clk) disable iff (!rst_n)
    dma_fill_req |-> (fill_en && fill_to_dma));

  a_r9_drain_dma_route: assert property (@(posedge clk) disable iff (!rst_n)
    dma_drain_req |-> (drain_en && drain_to_dma && drain_flag));

  a_r11_single_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_single && tx_count != 4'd0 && bus_tx_push && !shf_tx_pop && !tx_clear)
      |=> $stable(tx_count));
endmodule

bind spi_fifo_flags sfr_checker #(.DEPTH(DEPTH)) u_sfr_checker (
  .clk, .rst_n, .tx_clear, .rx_clear, .tx_single, .rx_overwrite,
  .bus_tx_push, .shf_tx_pop, .shf_rx_push, .bus_rx_pop,
  .flag_clr_we, .flag_clr_mask, .fill_en, .fill_to_dma, .drain_en, .drain_to_dma,
  .tx_count, .tx_next_ptr, .tx_load_en, .rx_count, .rx_store_en, .drain_flag,
  .flags, .dma_fill_req, .dma_drain_req, .tx_unf_evt, .rx_ovf_evt
);

// File: tb/test_spi_fifo_flags.sv
`timescale 1ns/1ps
module test_spi_fifo_flags;
  localparam int DEPTH = 4;

  logic clk, rst_n;
  logic tx_clear, rx_clear, tx_single, rx_single, rx_overwrite;
  logic bus_tx_push, shf_tx_pop, shf_rx_push, bus_rx_pop, eoq_evt, done_evt;
  logic flag_clr_we;
  logic [3:0] flag_clr_mask, flag_irq_en;
  logic fill_en, fill_to_dma, drain_en, drain_to_dma;
  logic [3:0] tx_count, tx_next_ptr, tx_store_addr, rx_count, rx_pop_ptr, rx_store_addr, flags;
  logic tx_store_en, tx_load_en, rx_store_en, rx_read_en;
  logic fill_flag, drain_flag, irq, dma_fill_req, dma_drain_req;

  spi_fifo_flags #(.DEPTH(DEPTH)) i_spi_fifo_flags (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural reference state
  int m_tc, m_tw, m_tr, m_rc, m_rw, m_rr;
  bit m_fl[4];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cap_of(input bit single);
    return single ? 1 : DEPTH;
  endfunction

  function automatic int nxt(input int p, input bit single);
    if (single) return 0;
    return (p + 1) % DEPTH;
  endfunction

  task automatic quiet;
    tx_clear = 0; rx_clear = 0; bus_tx_push = 0; shf_tx_pop = 0;
    shf_rx_push = 0; bus_rx_pop = 0; eoq_evt = 0; done_evt = 0;
    flag_clr_we = 0; flag_clr_mask = 4'h0;
  endtask

  task automatic compare_state;
    int exp_fill, exp_drain, exp_irq;
    exp_fill  = (m_tc < cap_of(tx_single)) ? 1 : 0;
    exp_drain = (m_rc != 0) ? 1 : 0;
    exp_irq   = 0;
    for (int i = 0; i < 4; i++) if (m_fl[i] && flag_irq_en[i]) exp_irq = 1;
    if (exp_fill && fill_en && !fill_to_dma) exp_irq = 1;
    if (exp_drain && drain_en && !drain_to_dma) exp_irq = 1;
    chk("R2", "tx_count", int'(tx_count), m_tc);
    chk("R2", "tx_next_ptr", int'(tx_next_ptr), m_tr);
    chk("R2", "rx_count", int'(rx_count), m_rc);
    chk("R2", "rx_pop_ptr", int'(rx_pop_ptr), m_rr);
    chk("R4", "fill_flag", int'(fill_flag), exp_fill);
    chk("R4", "drain_flag", int'(drain_flag), exp_drain);
    for (int i = 0; i < 4; i++) chk("R8", $sformatf("flags[%0d]", i), int'(flags[i]), int'(m_fl[i]));
    chk("R10", "irq", int'(irq), exp_irq);
    chk("R9", "dma_fill_req", int'(dma_fill_req), (exp_fill && fill_en && fill_to_dma) ? 1 : 0);
    chk("R9", "dma_drain_req", int'(dma_drain_req), (exp_drain && drain_en && drain_to_dma) ? 1 : 0);
  endtask

  // Inputs are set at a falling edge; one clock is run and everything compared.
  task automatic cyc;
    bit t_ok, t_rd, t_unf, r_ok, r_rd, r_ovf;
    bit set_ev[4];
    int back;
    #1;
    t_ok  = bus_tx_push && (m_tc < cap_of(tx_single));
    t_rd  = shf_tx_pop && (m_tc > 0);
    t_unf = shf_tx_pop && (m_tc == 0);
    r_ok  = shf_rx_push && (m_rc < cap_of(rx_single));
    r_rd  = bus_rx_pop && (m_rc > 0);
    r_ovf = shf_rx_push && !r_ok;
    chk("R2", "tx_store_en", int'(tx_store_en), int'(t_ok));
    if (t_ok) chk("R2", "tx_store_addr", int'(tx_store_addr), m_tw);
    chk("R7", "tx_load_en", int'(tx_load_en), int'(t_rd));
    chk("R5", "rx_store_en", int'(rx_store_en), int'(r_ok || (r_ovf && rx_overwrite)));
    if (r_ok) chk("R2", "rx_store_addr", int'(rx_store_addr), m_rw);
    if (r_ovf && rx_overwrite) begin
      back = rx_single ? 0 : ((m_rw + DEPTH - 1) % DEPTH);
      chk("R6", "rx_store_addr", int'(rx_store_addr), back);
    end
    chk("R2", "rx_read_en", int'(rx_read_en), int'(r_rd));
    set_ev[0] = r_ovf; set_ev[1] = t_unf; set_ev[2] = eoq_evt; set_ev[3] = done_evt;
    @(posedge clk);
    if (tx_clear) begin m_tc = 0; m_tw = 0; m_tr = 0; end
    else begin
      m_tc = m_tc + int'(t_ok) - int'(t_rd);
      if (t_ok) m_tw = nxt(m_tw, tx_single);
      if (t_rd) m_tr = nxt(m_tr, tx_single);
    end
    if (rx_clear) begin m_rc = 0; m_rw = 0; m_rr = 0; end
    else begin
      m_rc = m_rc + int'(r_ok) - int'(r_rd);
      if (r_ok) m_rw = nxt(m_rw, rx_single);
      if (r_rd) m_rr = nxt(m_rr, rx_single);
    end
    for (int i = 0; i < 4; i++)
      if (set_ev[i]) m_fl[i] = 1;
      else if (flag_clr_we && flag_clr_mask[i]) m_fl[i] = 0;
    @(negedge clk);
    compare_state();
    quiet();
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    quiet();
    rst_n = 0; tx_single = 0; rx_single = 0; rx_overwrite = 0;
    fill_en = 0; fill_to_dma = 0; drain_en = 0; drain_to_dma = 0; flag_irq_en = 4'h0;
    m_tc = 0; m_tw = 0; m_tr = 0; m_rc = 0; m_rw = 0; m_rr = 0;
    for (int i = 0; i < 4; i++) m_fl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tx_count", int'(tx_count), 0);
    chk("R1", "rx_count", int'(rx_count), 0);
    chk("R1", "flags", int'(flags), 0);
    chk("R1", "fill_flag", int'(fill_flag), 1);
    chk("R1", "drain_flag", int'(drain_flag), 0);
    chk("R1", "irq/dma", int'({irq, dma_fill_req, dma_drain_req}), 0);

    // R2/R4/R9: fill transmit past capacity with room routed to DMA
    fill_en = 1; fill_to_dma = 1;
    for (int k = 0; k < DEPTH + 1; k++) begin bus_tx_push = 1; cyc(); end
    chk("R2", "tx full level", int'(tx_count), DEPTH);
    chk("R4", "room flag when full", int'(fill_flag), 0);
    chk("R9", "dma fill off when full", int'(dma_fill_req), 0);
    // simultaneous push and pop at full: push refused, pop taken
    bus_tx_push = 1; shf_tx_pop = 1; cyc();
    chk("R2", "level after pop at full", int'(tx_count), DEPTH - 1);
    bus_tx_push = 1; shf_tx_pop = 1; cyc();
    chk("R2", "level with push+pop", int'(tx_count), DEPTH - 1);

    // R7/R10: drain transmit past empty, underflow routed to interrupt
    fill_to_dma = 0; flag_irq_en = 4'b0010;
    for (int k = 0; k < DEPTH + 1; k++) begin shf_tx_pop = 1; cyc(); end
    chk("R7", "underflow flag", int'(flags[1]), 1);
    chk("R7", "level at empty", int'(tx_count), 0);
    chk("R10", "irq from underflow", int'(irq), 1);
    // R8: clear with a same-cycle set keeps the bit, plain clear drops it
    flag_clr_we = 1; flag_clr_mask = 4'b0010; shf_tx_pop = 1; cyc();
    chk("R8", "set wins over clear", int'(flags[1]), 1);
    flag_clr_we = 1; flag_clr_mask = 4'b0010; cyc();
    chk("R8", "write-one clears", int'(flags[1]), 0);
    fill_en = 0; flag_irq_en = 4'h0;

    // R5: receive overflow in drop mode
    drain_en = 1; drain_to_dma = 1;
    for (int k = 0; k < DEPTH; k++) begin shf_rx_push = 1; cyc(); end
    chk("R9", "dma drain when data", int'(dma_drain_req), 1);
    shf_rx_push = 1; cyc();
    chk("R5", "overflow flag", int'(flags[0]), 1);
    chk("R5", "level held", int'(rx_count), DEPTH);
    // R6: overwrite newest entry (write position wrapped to 0 -> DEPTH-1)
    rx_overwrite = 1; shf_rx_push = 1; cyc();
    chk("R6", "level held in overwrite", int'(rx_count), DEPTH);
    rx_overwrite = 0;
    // R9: data flag routed to interrupt
    drain_to_dma = 0; cyc();
    chk("R9", "irq from data flag", int'(irq), 1);
    chk("R9", "no dma when select 0", int'(dma_drain_req), 0);
    // R3: clear overrides a same-cycle pop
    rx_clear = 1; bus_rx_pop = 1; cyc();
    chk("R3", "rx level cleared", int'(rx_count), 0);
    chk("R3", "rx pointer cleared", int'(rx_pop_ptr), 0);
    drain_en = 0;
    flag_clr_we = 1; flag_clr_mask = 4'hF; cyc();

    // R10: end-of-queue and done only interrupt when enabled
    eoq_evt = 1; done_evt = 1; cyc();
    chk("R10", "masked flags give no irq", int'(irq), 0);
    flag_irq_en = 4'b1000; cyc();
    chk("R10", "done flag irq", int'(irq), 1);
    flag_irq_en = 4'h0; flag_clr_we = 1; flag_clr_mask = 4'hF; cyc();

    // R11: single-entry transmit
    tx_clear = 1; cyc();
    tx_single = 1;
    bus_tx_push = 1; cyc();
    bus_tx_push = 1; cyc();
    chk("R11", "single level", int'(tx_count), 1);
    shf_tx_pop = 1; cyc();
    chk("R11", "single pointer", int'(tx_next_ptr), 0);
    tx_single = 0;

    // Mixed random traffic compared every clock
    seed = 7;
    void'($urandom(seed));
    for (int k = 0; k < 2000; k++) begin
      bus_tx_push  = ($urandom % 2) == 0;
      shf_tx_pop   = ($urandom % 3) == 0;
      shf_rx_push  = ($urandom % 2) == 0;
      bus_rx_pop   = ($urandom % 3) == 0;
      eoq_evt      = ($urandom % 17) == 0;
      done_evt     = ($urandom % 13) == 0;
      tx_clear     = ($urandom % 41) == 0;
      rx_clear     = ($urandom % 43) == 0;
      flag_clr_we  = ($urandom % 5) == 0;
      flag_clr_mask = 4'($urandom);
      rx_overwrite = ($urandom % 2) == 0;
      fill_en      = ($urandom % 2) == 0;
      fill_to_dma  = ($urandom % 2) == 0;
      drain_en     = ($urandom % 2) == 0;
      drain_to_dma = ($urandom % 2) == 0;
      flag_irq_en  = 4'($urandom);
      cyc();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule